// File: doc/BRIEF.md
# Scanline Display Timing Controller

This block produces line and frame timing for a 240 by 160 panel. It advances once per cycle on which the pixel-cycle enable is high. A pixel is four such cycles. Each visible line has a drawing period of 960 cycles and then a horizontal blanking period of 272 cycles. After the 160 visible lines come 68 blanking lines of the same length, so a frame has 228 lines.

A 16-bit register bus reaches two registers. The status register at address 0 holds three live flags: vertical blank, horizontal blank and line-match. It also holds three interrupt enables and an 8-bit compare line. The register at address 1 returns the current line number and cannot be written. The block drives three interrupt request pulses and a line-start strobe for a pixel renderer.

All period lengths are parameters. The defaults give the timing above. The bench uses short periods so that whole frames fit in a short run.

Top module: `lcd_line_timer`

## Requirements
- R1: After reset the block is drawing line 0, and both blank flags, all enables and the compare line are zero. Status therefore reads 0x0004, the line register reads 0, and every output pulse is low.
- R2: The cycle position advances only on clocks where `pix_ce` is high. A line lasts H_DRAW_CYC + H_BLANK_CYC enabled cycles. On a visible line, status bit 1 (horizontal blank) is high for the last H_BLANK_CYC of those cycles.
- R3: Status bit 0 (vertical blank) is high exactly while the line is in VIS_LINES to ALL_LINES-1, and bit 1 is low during that time. After line ALL_LINES-1 the line number returns to 0 and drawing starts again.
- R4: Reading address 1 returns the current line in bits 7:0 and zero in bits 15:8.
- R5: Status bit 2 (line-match) is high whenever the current line equals the compare line held in status bits 15:8.
- R6: A write to address 0 updates only bits 3 to 5 and 8 to 15. Flag bits 0 to 2 ignore written data. A write to address 1 has no effect.
- R7: Each of `irq_vblank`, `irq_hblank` and `irq_match` is a one-clock pulse on the rising edge of its flag (bit 0, 1 or 2). Each pulse is gated by its enable in status bit 3, 4 or 5 respectively. No pulse occurs while that enable is clear.
- R8: `line_start` pulses for one clock each time a visible line begins its drawing period, including line 0 after vertical blank. It does not pulse when vertical blank is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-cycle enable; one timing cycle per high clock |
| bus_addr | input | 1 | Register select: 0 status, 1 line number |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register (combinational) |
| irq_vblank | output | 1 | Vertical-blank interrupt pulse |
| irq_hblank | output | 1 | Horizontal-blank interrupt pulse |
| irq_match | output | 1 | Line-match interrupt pulse |
| line_start | output | 1 | Start-of-visible-line strobe |

## Verification
The assertions assume that ALL_LINES is at most 256, so the line always fits the 8-bit compare field. They also assume that VIS_LINES is below ALL_LINES and that the enable may stay low for any number of clocks. The bench uses periods of 6 and 3 cycles and frames of 3 visible lines out of 5, which keeps these conditions true. The bench pauses the enable between timing cycles and makes every register write on a clock with the enable low. As a result, each flag edge comes from a single cause.

// File: rtl/lcd_line_timer.sv
module lcd_line_timer #(
  parameter int H_DRAW_CYC  = 960,
  parameter int H_BLANK_CYC = 272,
  parameter int VIS_LINES   = 160,
  parameter int ALL_LINES   = 228
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_ce,
  input  logic        bus_addr,
  input  logic        bus_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_vblank,
  output logic        irq_hblank,
  output logic        irq_match,
  output logic        line_start
);
  localparam int LINE_CYC = H_DRAW_CYC + H_BLANK_CYC;
  localparam int CYC_W    = $clog2(LINE_CYC);

  typedef enum logic [1:0] {PH_DRAW, PH_HBLANK, PH_VBLANK} phase_t;

  phase_t           phase;
  logic [CYC_W-1:0] cyc;
  logic [7:0]       line;
  logic [7:0]       line_nx;
  logic [7:0]       cmp;
  logic             en_v, en_h, en_m;
  logic             vbl_q, hbl_q, match_q, draw_q;

  wire end_of_draw = cyc == CYC_W'(H_DRAW_CYC - 1);
  wire end_of_line = cyc == CYC_W'(LINE_CYC - 1);
  wire last_line   = line == 8'(ALL_LINES - 1);
  wire vbl         = phase == PH_VBLANK;
  wire hbl         = phase == PH_HBLANK;
  wire drawing     = phase == PH_DRAW;
  wire match       = line == cmp;
  wire unused_wbits = ^{bus_wdata[7:6], bus_wdata[2:0]};

  assign line_nx = last_line ? 8'd0 : line + 8'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_DRAW;
      cyc   <= '0;
      line  <= '0;
    end else if (pix_ce) begin
      if (end_of_line) begin
        cyc   <= '0;
        line  <= line_nx;
        phase <= (line_nx < 8'(VIS_LINES)) ? PH_DRAW : PH_VBLANK;
      end else begin
        cyc <= cyc + CYC_W'(1);
        if (end_of_draw && drawing) phase <= PH_HBLANK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbl_q   <= 1'b0;
      hbl_q   <= 1'b0;
      match_q <= 1'b1;
      draw_q  <= 1'b1;
    end else begin
      vbl_q   <= vbl;
      hbl_q   <= hbl;
      match_q <= match;
      draw_q  <= drawing;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp  <= '0;
      en_v <= 1'b0;
      en_h <= 1'b0;
      en_m <= 1'b0;
    end else if (bus_we && !bus_addr) begin
      cmp  <= bus_wdata[15:8];
      en_m <= bus_wdata[5];
      en_h <= bus_wdata[4];
      en_v <= bus_wdata[3];
    end
  end

  assign bus_rdata  = bus_addr ? {8'd0, line}
                               : {cmp, 2'b00, en_m, en_h, en_v, match, hbl, vbl};
  assign irq_vblank = en_v && vbl && !vbl_q;
  assign irq_hblank = en_h && hbl && !hbl_q;
  assign irq_match  = en_m && match && !match_q;
  assign line_start = drawing && !draw_q;

  AST_LINE_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) line < 8'(ALL_LINES)); // R3
  AST_VBL_LINES:     assert property (@(posedge clk) disable iff (!rst_n) vbl == (line >= 8'(VIS_LINES))); // R3
  AST_NO_HBL_IN_VBL: assert property (@(posedge clk) disable iff (!rst_n) !(vbl && hbl)); // R3
  AST_FRAME_WRAP:    assert property (@(posedge clk) disable iff (!rst_n)
                       (pix_ce && end_of_line && last_line) |=> (line == 8'd0 && drawing)); // R3
  AST_CE_FREEZE:     assert property (@(posedge clk) disable iff (!rst_n)
                       !pix_ce |=> ($stable(cyc) && $stable(line))); // R2
  AST_HIRQ_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) irq_hblank |=> !irq_hblank); // R7
  AST_VIRQ_GATED:    assert property (@(posedge clk) disable iff (!rst_n) irq_vblank |-> en_v); // R7
  AST_MIRQ_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) irq_match |=> !irq_match); // R7
  AST_LS_PULSE:      assert property (@(posedge clk) disable iff (!rst_n) line_start |=> !line_start); // R8
  AST_LS_VISIBLE:    assert property (@(posedge clk) disable iff (!rst_n) line_start |-> line < 8'(VIS_LINES)); // R8
endmodule

// File: tb/lcd_line_timer_bench.sv
module lcd_line_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b0;
  logic        bus_addr = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_vblank, irq_hblank, irq_match, line_start;
  int          errors = 0;
  int          checks = 0;
  int          ticks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  lcd_line_timer #(.H_DRAW_CYC(6), .H_BLANK_CYC(3), .VIS_LINES(3), .ALL_LINES(5)) u_lcd_line_timer (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_vblank(irq_vblank),
    .irq_hblank(irq_hblank), .irq_match(irq_match), .line_start(line_start));

  // {ticks since reset, line, vblank, hblank}; line = 9 ticks, 6 drawing, 3 visible of 5
  localparam logic [15:0] VEC [12] = '{
    {8'd0, 6'd0, 1'b0, 1'b0}, {8'd5, 6'd0, 1'b0, 1'b0}, {8'd6, 6'd0, 1'b0, 1'b1},
    {8'd8, 6'd0, 1'b0, 1'b1}, {8'd9, 6'd1, 1'b0, 1'b0}, {8'd24, 6'd2, 1'b0, 1'b1},
    {8'd26, 6'd2, 1'b0, 1'b1}, {8'd27, 6'd3, 1'b1, 1'b0}, {8'd35, 6'd3, 1'b1, 1'b0},
    {8'd36, 6'd4, 1'b1, 1'b0}, {8'd44, 6'd4, 1'b1, 1'b0}, {8'd45, 6'd0, 1'b0, 1'b0}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pix_ce = 1'b0; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; ticks = 0;
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk); pix_ce = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); pix_ce = 1'b0;
    ticks += n;
  endtask

  task automatic goto(input int t);
    step(t - ticks);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    logic [15:0] v;
    do_reset();
    rd(1'b0, v); check("R1 status", v, 16'h0004);
    rd(1'b1, v); check("R1 line", v, 16'h0000);
    check("R1 pulses", {12'd0, irq_vblank, irq_hblank, irq_match, line_start}, 16'h0);

    for (int i = 0; i < 12; i++) begin
      goto(int'(VEC[i][15:8]));
      rd(1'b1, v); check("R4 line", v, {8'd0, 2'b00, VEC[i][7:2]});
      rd(1'b0, v); check("R2 R3 flags", {14'd0, v[1:0]}, {14'd0, VEC[i][0], VEC[i][1]});
    end

    // R2 idle clocks with pix_ce low do not advance timing
    do_reset();
    goto(5);
    repeat (10) @(negedge clk);
    rd(1'b0, v); check("R2 frozen hblank", {15'd0, v[1]}, 16'h0);
    rd(1'b1, v); check("R2 frozen line", v, 16'h0);
    step(1);
    rd(1'b0, v); check("R2 hblank after gap", {15'd0, v[1]}, 16'h1);

    // R6 register write masking
    do_reset();
    wr(1'b0, 16'hFFFF);
    rd(1'b0, v); check("R6 flags ignored", v, 16'hFF38);
    wr(1'b1, 16'h00AA);
    rd(1'b1, v); check("R6 line write ignored", v, 16'h0000);
    wr(1'b0, 16'h0007);
    rd(1'b0, v); check("R6 clear", v, 16'h0004);

    // R5 line match
    wr(1'b0, 16'h0200);
    goto(9);  rd(1'b0, v); check("R5 no match line1", {15'd0, v[2]}, 16'h0);
    goto(18); rd(1'b0, v); check("R5 match line2", {15'd0, v[2]}, 16'h1);

    // R7 hblank interrupt disabled
    do_reset();
    goto(6); check("R7 hblank irq gated off", {15'd0, irq_hblank}, 16'h0);

    // R7 hblank interrupt enabled
    do_reset();
    wr(1'b0, 16'h0010);
    goto(6); check("R7 hblank irq", {15'd0, irq_hblank}, 16'h1);
    @(negedge clk); check("R7 hblank irq one cycle", {15'd0, irq_hblank}, 16'h0);

    // R7 match interrupt on line 1, R8 line start
    do_reset();
    wr(1'b0, 16'h0120);
    goto(8); check("R7 match irq early", {15'd0, irq_match}, 16'h0);
    goto(9);
    check("R7 match irq", {15'd0, irq_match}, 16'h1);
    check("R8 line start", {15'd0, line_start}, 16'h1);
    @(negedge clk);
    check("R7 match irq one cycle", {15'd0, irq_match}, 16'h0);
    check("R8 line start one cycle", {15'd0, line_start}, 16'h0);

    // R7 vblank interrupt, R8 no strobe at vblank, strobe at line 0
    do_reset();
    wr(1'b0, 16'h0008);
    goto(27);
    check("R7 vblank irq", {15'd0, irq_vblank}, 16'h1);
    check("R8 no strobe at vblank", {15'd0, line_start}, 16'h0);
    @(negedge clk); check("R7 vblank irq one cycle", {15'd0, irq_vblank}, 16'h0);
    goto(45); check("R8 strobe at line 0", {15'd0, line_start}, 16'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule